// File: doc/BRIEF.md
# Serial Control-Bus Register Bank Slave

This block lets a two-wire serial bus master (I2C protocol, standard and fast rates) load a bank of twelve 8-bit control registers and read them back. It watches the synchronised SCL and SDA lines and picks out START and STOP conditions. It checks a 7-bit device address made of a fixed 6-bit type code and one bit set by a strapping pin. It acknowledges each byte it accepts.

On a write, the byte after the address is a subaddress. It holds a register index, an auto-increment flag and three test bits, which are ignored. Data bytes that follow land in the register the pointer selects. When the flag is set, the pointer then steps on by one.

On a read, the slave shifts out the register at the current pointer, most significant bit first. The whole bank is always visible as one flat parallel output. The outputs are plain levels with no valid/ready handshake. The bus cannot stall the master because this slave never stretches the clock, so the block has no back-pressure path. SDA is open-drain: the block only ever asks for the line to be pulled low.

Top module: `i2c_ctl_bank`

## Requirements
- R1: The address byte (first byte after START) is accepted only when bits 7:2 equal 110001 and bit 1 equals `addr_sel`. Bit 0 selects read (1) or write (0). A mismatching address gets no acknowledge, and the slave ignores the bus until the next START.
- R2: For each accepted byte the slave pulls SDA low through the ninth SCL clock. `sda_pull_low` changes only after an SCL falling edge, a START or a STOP, never while SCL is high.
- R3: SDA is sampled on SCL rising edges. SDA falling while SCL is high is a START, and SDA rising while SCL is high is a STOP. A START, including a repeated START, discards a partly received byte.
- R4: In the subaddress byte, bits 3:0 are the register index and bit 4 enables auto-increment. Bits 7:5 are test bits and have no effect.
- R5: A data byte written to index i (0 to 11) appears on `reg_q[8*i+7:8*i]`. All registers reset to 0x00.
- R6: With auto-increment set, the pointer advances by one after every data byte. It wraps from 15 to 0. Bytes addressed to indices 12 to 15 are acknowledged but change no register.
- R7: With auto-increment clear, successive data bytes all overwrite the same register.
- R8: A STOP returns the interface to idle and releases SDA. A partly received byte is discarded.
- R9: A read shifts out the register at the pointer, MSB first. Indices 12 to 15 read as 0x00. After a master ACK the next byte follows, with the pointer advanced if auto-increment is set. After a NACK the slave releases SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_sel | input | 1 | Strapped value of address bit 1 |
| sda_pull_low | output | 1 | High to pull SDA low (open-drain) |
| reg_q | output | 96 | All twelve registers, index i at bits 8*i+7:8*i |

## Verification
Storing a data byte and stepping the pointer happen on the same edge, so the wrap from 15 to 0 is the sharp case. A burst starts at index 11 and runs through the four discarded indices. The bench then checks that exactly registers 11 and 0 changed and that every byte was acknowledged. A START or STOP can also land in the middle of byte shifting. The bench cuts a byte short with each of them and judges at `reg_q` that nothing was stored and that the next transaction still works.

// File: rtl/i2c_bank_pkg.sv
package i2c_bank_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RECV, S_ACK, S_SEND, S_RACK
  } bus_st_t;

  typedef enum logic [1:0] {
    P_ADDR, P_SUB, P_DATA, P_READ
  } phase_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES:0] scl_pipe, sda_pipe;
  logic scl_s, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_i};
      sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_i};
    end
  end

  assign scl_s = scl_pipe[SYNC_STAGES-1];
  assign scl_q = scl_pipe[SYNC_STAGES];
  assign sda_s = sda_pipe[SYNC_STAGES-1];
  assign sda_q = sda_pipe[SYNC_STAGES];

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int N_REGS = 12,
  parameter int DW     = 8,
  parameter int IDX_W  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [DW-1:0]        wr_data,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [DW-1:0]        rd_data,
  output logic [N_REGS*DW-1:0] regs_flat
);
  logic [DW-1:0] regs [N_REGS];

  for (genvar g = 0; g < N_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[g] <= '0;
      else if (wr_en && int'(wr_idx) == g)
        regs[g] <= wr_data;
    end
    assign regs_flat[g*DW +: DW] = regs[g];
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N_REGS; i++)
      if (int'(rd_idx) == i) rd_data = regs[i];
  end

  // R6: indices past the bank leave every register untouched
  a_r6_high_index_discarded: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) >= N_REGS) |=> $stable(regs_flat));

  // R5: an in-range write shows up on the flat output
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && int'(wr_idx) < N_REGS) |=> regs_flat[$past(wr_idx)*DW +: DW] == $past(wr_data));
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
  import i2c_bank_pkg::*;
#(
  parameter int          DW       = 8,
  parameter int          IDX_W    = 4,
  parameter logic [5:0]  DEV_TYPE = 6'b110001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             addr_sel,
  input  logic [DW-1:0]    rd_data,
  output logic             sda_drive,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [DW-1:0]    wr_data,
  output logic [IDX_W-1:0] ptr
);
  localparam int CNT_W = $clog2(DW + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DW);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DW - 1);

  bus_st_t         st;
  phase_t          ph;
  logic [CNT_W-1:0] cnt;
  logic [DW-1:0]   sh;
  logic            rw, inc, got_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; ph <= P_ADDR; cnt <= '0; sh <= '0;
      rw <= 1'b0; inc <= 1'b0; got_ack <= 1'b0; ptr <= '0;
      sda_drive <= 1'b0; wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        st <= S_IDLE;
        sda_drive <= 1'b0;
      end else if (start_det) begin
        st <= S_RECV;
        ph <= P_ADDR;
        cnt <= '0;
        sda_drive <= 1'b0;
      end else begin
        case (st)
          S_RECV: begin
            if (scl_rise && cnt != FULL) begin
              sh  <= {sh[DW-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              cnt <= '0;
              case (ph)
                P_ADDR: begin
                  if (sh[DW-1:1] == {DEV_TYPE, addr_sel}) begin
                    rw <= sh[0];
                    sda_drive <= 1'b1;
                    st <= S_ACK;
                  end else begin
                    st <= S_IDLE;
                  end
                end
                P_SUB: begin
                  ptr <= sh[IDX_W-1:0];
                  inc <= sh[IDX_W];
                  sda_drive <= 1'b1;
                  st <= S_ACK;
                end
                default: begin
                  wr_en   <= 1'b1;
                  wr_idx  <= ptr;
                  wr_data <= sh;
                  if (inc) ptr <= ptr + 1'b1;
                  sda_drive <= 1'b1;
                  st <= S_ACK;
                end
              endcase
            end
          end
          S_ACK: begin
            if (scl_fall) begin
              if (ph == P_ADDR && rw) begin
                st <= S_SEND;
                ph <= P_READ;
                sh <= rd_data;
                sda_drive <= ~rd_data[DW-1];
                cnt <= '0;
              end else begin
                st <= S_RECV;
                ph <= (ph == P_ADDR) ? P_SUB : P_DATA;
                sda_drive <= 1'b0;
              end
            end
          end
          S_SEND: begin
            if (scl_fall) begin
              if (cnt == LAST) begin
                sda_drive <= 1'b0;
                cnt <= '0;
                st <= S_RACK;
                if (inc) ptr <= ptr + 1'b1;
              end else begin
                sh <= {sh[DW-2:0], 1'b0};
                sda_drive <= ~sh[DW-2];
                cnt <= cnt + 1'b1;
              end
            end
          end
          S_RACK: begin
            if (scl_rise) begin
              got_ack <= ~sda_s;
            end else if (scl_fall) begin
              if (got_ack) begin
                st <= S_SEND;
                sh <= rd_data;
                sda_drive <= ~rd_data[DW-1];
              end else begin
                st <= S_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: the pull-down only engages just after SCL falls
  a_r2_pull_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_drive) |-> $past(scl_fall));

  // R2: the pull-down only lets go after SCL falls or a bus condition
  a_r2_release_when_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_drive) |-> $past(scl_fall || stop_det || start_det));

  // R8: a STOP leaves the line released and the engine idle
  a_r8_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!sda_drive && st == S_IDLE));

  // R6: a stored byte is followed by a pointer one further on
  a_r6_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && inc) |-> ptr == IDX_W'(wr_idx + 1'b1));

  // R7: without auto-increment the pointer stays on the written register
  a_r7_ptr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !inc) |-> ptr == wr_idx);
endmodule

// File: rtl/i2c_ctl_bank.sv
module i2c_ctl_bank #(
  parameter int         N_REGS   = 12,
  parameter int         DW       = 8,
  parameter int         IDX_W    = 4,
  parameter logic [5:0] DEV_TYPE = 6'b110001
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic                 addr_sel,
  output logic                 sda_pull_low,
  output logic [N_REGS*DW-1:0] reg_q
);
  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [IDX_W-1:0] wr_idx, ptr;
  logic [DW-1:0] wr_data, rd_data;

  i2c_line_sync #(.SYNC_STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_byte_engine #(.DW(DW), .IDX_W(IDX_W), .DEV_TYPE(DEV_TYPE)) u_eng (
    .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .addr_sel(addr_sel), .rd_data(rd_data), .sda_drive(sda_pull_low),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .ptr(ptr)
  );

  i2c_reg_bank #(.N_REGS(N_REGS), .DW(DW), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(ptr), .rd_data(rd_data), .regs_flat(reg_q)
  );
endmodule

// File: tb/i2c_ctl_bank_tb.sv
module i2c_ctl_bank_tb;
  localparam int Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic addr_sel = 1'b1;
  logic sda_pull_low;
  logic [95:0] reg_q;
  logic sda_line;
  logic [7:0] model [12];
  int total = 0;
  int bad = 0;
  bit done = 0;

  assign sda_line = sda_m & ~sda_pull_low;

  always #2 clk = ~clk;

  i2c_ctl_bank u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .addr_sel(addr_sel), .sda_pull_low(sda_pull_low), .reg_q(reg_q)
  );

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [95:0] model_flat();
    logic [95:0] v;
    for (int i = 0; i < 12; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  task automatic q_wait(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q_wait(1);
    scl_m = 1'b1; q_wait(1);
    sda_m = 1'b0; q_wait(1);
    scl_m = 1'b0; q_wait(1);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q_wait(1);
    scl_m = 1'b1; q_wait(1);
    sda_m = 1'b1; q_wait(1);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; q_wait(1);
      scl_m = 1'b1; q_wait(2);
      scl_m = 1'b0; q_wait(1);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_m = 1'b1; q_wait(1);
    scl_m = 1'b1; q_wait(1);
    ack = sda_line; q_wait(1);
    scl_m = 1'b0; q_wait(1);
  endtask

  task automatic rd_byte(input logic master_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q_wait(1);
      scl_m = 1'b1; q_wait(1);
      b[i] = sda_line; q_wait(1);
      scl_m = 1'b0;
    end
    q_wait(1);
    sda_m = ~master_ack; q_wait(1);
    scl_m = 1'b1; q_wait(2);
    scl_m = 1'b0; q_wait(1);
    sda_m = 1'b1;
  endtask

  task automatic t_reset();
    chk("R5 reset registers", reg_q, '0);
    chk("R2 reset line released", {95'd0, sda_pull_low}, '0);
  endtask

  task automatic t_write_inc();
    logic a;
    logic [2:0] acks;
    bus_start();
    wr_byte(8'hC6, a); chk("R1 address ack", {95'd0, a}, '0);
    wr_byte(8'h12, a); chk("R2 subaddress ack", {95'd0, a}, '0);
    wr_byte(8'hA1, acks[0]); wr_byte(8'hA2, acks[1]); wr_byte(8'hA3, acks[2]);
    bus_stop();
    chk("R2 data acks", {93'd0, acks}, '0);
    model[2] = 8'hA1; model[3] = 8'hA2; model[4] = 8'hA3;
    chk("R5 R6 auto-increment burst", reg_q, model_flat());
  endtask

  task automatic t_write_noinc();
    logic a;
    bus_start();
    wr_byte(8'hC6, a); wr_byte(8'h05, a);
    wr_byte(8'h11, a); wr_byte(8'h22, a);
    bus_stop();
    model[5] = 8'h22;
    chk("R7 same register overwritten", reg_q, model_flat());
    chk("R7 neighbour untouched", {88'd0, reg_q[6*8 +: 8]}, '0);
  endtask

  task automatic t_wrap();
    logic a;
    logic [5:0] acks;
    logic [7:0] d [6];
    d[0] = 8'hB1; d[1] = 8'hC1; d[2] = 8'hD1; d[3] = 8'hE1; d[4] = 8'hF1; d[5] = 8'h0A;
    bus_start();
    wr_byte(8'hC6, a); wr_byte(8'h1B, a);
    for (int i = 0; i < 6; i++) wr_byte(d[i], acks[i]);
    bus_stop();
    chk("R6 discarded indices still acked", {90'd0, acks}, '0);
    model[11] = 8'hB1; model[0] = 8'h0A;
    chk("R6 wrap 15 to 0", reg_q, model_flat());
  endtask

  task automatic t_test_bits();
    logic a;
    bus_start();
    wr_byte(8'hC6, a); wr_byte(8'hE8, a); wr_byte(8'h88, a); wr_byte(8'h89, a);
    bus_stop();
    model[8] = 8'h89;
    chk("R4 test bits ignored", reg_q, model_flat());
  endtask

  task automatic t_addr_mismatch();
    logic a1, a2, a3;
    addr_sel = 1'b1;
    bus_start();
    wr_byte(8'hC4, a1); wr_byte(8'h01, a2); wr_byte(8'h55, a3);
    bus_stop();
    chk("R1 wrong select bit nack", {93'd0, a1, a2, a3}, 96'h7);
    bus_start();
    wr_byte(8'h86, a1); wr_byte(8'h01, a2);
    bus_stop();
    chk("R1 wrong type nack", {94'd0, a1, a2}, 96'h3);
    chk("R1 mismatch leaves bank", reg_q, model_flat());
    addr_sel = 1'b0;
    bus_start();
    wr_byte(8'hC4, a1); wr_byte(8'h01, a2); wr_byte(8'h3C, a3);
    bus_stop();
    model[1] = 8'h3C;
    chk("R1 select pin low accepted", {93'd0, a1, a2, a3}, '0);
    chk("R1 select pin low write", reg_q, model_flat());
    addr_sel = 1'b1;
  endtask

  task automatic t_read();
    logic a;
    logic [7:0] b0, b1;
    bus_start();
    wr_byte(8'hC6, a); wr_byte(8'h12, a);
    bus_start();
    wr_byte(8'hC7, a); chk("R9 read address ack", {95'd0, a}, '0);
    rd_byte(1'b1, b0); rd_byte(1'b0, b1);
    bus_stop();
    chk("R9 read first byte", {88'd0, b0}, {88'd0, model[2]});
    chk("R9 read advanced byte", {88'd0, b1}, {88'd0, model[3]});
    chk("R9 released after nack", {95'd0, sda_pull_low}, '0);
    bus_start();
    wr_byte(8'hC6, a); wr_byte(8'h0D, a);
    bus_start();
    wr_byte(8'hC7, a); rd_byte(1'b0, b0);
    bus_stop();
    chk("R9 unimplemented index reads zero", {88'd0, b0}, '0);
  endtask

  task automatic t_stop_mid();
    logic a;
    bus_start();
    wr_byte(8'hC6, a); wr_byte(8'h07, a);
    send_bits(8'hFF, 4);
    bus_stop();
    chk("R8 partial byte dropped at STOP", reg_q, model_flat());
    chk("R8 line released", {95'd0, sda_pull_low}, '0);
    bus_start();
    wr_byte(8'hC6, a); wr_byte(8'h07, a); wr_byte(8'h77, a);
    bus_stop();
    model[7] = 8'h77;
    chk("R8 recovery after STOP", reg_q, model_flat());
  endtask

  task automatic t_restart_mid();
    logic a;
    bus_start();
    wr_byte(8'hC6, a); wr_byte(8'h09, a);
    send_bits(8'hFF, 3);
    bus_start();
    chk("R3 repeated START drops partial byte", reg_q, model_flat());
    wr_byte(8'hC6, a); wr_byte(8'h09, a); wr_byte(8'h99, a);
    bus_stop();
    model[9] = 8'h99;
    chk("R3 transfer after repeated START", reg_q, model_flat());
  endtask

  initial begin
    for (int i = 0; i < 12; i++) model[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_inc();
    t_write_noinc();
    t_wrap();
    t_test_bits();
    t_addr_mismatch();
    t_read();
    t_stop_mid();
    t_restart_mid();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule